// File: doc/BRIEF.md
# Embedded-sync video capture parser

This block sits at the input of a video capture path and serves a single pixel-clock domain. Each clock it takes one sample. The sample is either an 8-bit word of a stream that carries its timing as in-band reference codes, or a pixel of a stream that comes with separate horizontal sync, vertical sync and data-enable pins. From whichever timing it is given, the block recovers the field, vertical-blanking and horizontal-blanking state. Active picture samples go out as a pixel stream with a source index and line and frame markers.

In embedded mode one physical port can carry lines from several time-multiplexed sources. Each line's reference code names its source. Index 8 is reserved for the split-line source, which gives nine sources in total. Samples that fall inside the vertical blanking interval may carry ancillary data. They leave through a separate ancillary stream tagged with the same source index, so that a downstream buffer can be kept for each source. For 4:2:2 luma/chroma streams the ancillary path can keep luma only, chroma only or both. For three-colour streams it keeps one chosen colour. Horizontal-blanking samples are captured only in discrete-sync mode, and only when enabled.

Each reference code is checked with its protection bits. A corrupt code is dropped, and the drop is recorded in a sticky error flag.

Top module: `vid_capture_parser`

## Requirements
- R1: In embedded mode a timing reference is the word sequence 0xFF, 0x00, S, XY, where S is 0x00 unless multiplexing is on. In XY, bit 7 is 1, bit 6 is the field flag, bit 5 is vertical blanking and bit 4 is H (0 = start of active video, 1 = end). When a valid code arrives, `field`, `vblank` and `hblank` take these values in the cycle after XY is sampled. None of the four words ever appears on the pixel or ancillary stream.
- R2: Protection bits of XY are bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. A code whose protection bits are wrong, or whose bit 7 is 0, changes no state and sets `code_err`. `code_err` stays at 1 until reset.
- R3: After a valid start code with V=0, each following non-code word is output on `pix_data` with `pix_valid` one cycle later. This holds until the end code. `pix_sol` marks the first such pixel of the line.
- R4: `pix_sof` is set on the first active pixel after a valid code with V=1 (embedded) or after vsync was high (discrete). It is set on no other pixel, and is always set together with `pix_sol`.
- R5: With multiplexing on, the low 4 bits of word S give the source index 0..8 (8 = split-line source), and the upper bits must be 0. This index tags the pixels and ancillary samples of the line that follows. An S with index 9 or above, or with non-zero upper bits, aborts the code; the line is not opened. With multiplexing off, S must be 0x00 and the index is 0.
- R6: In embedded mode, samples between a start code with V=1 and the next end code go to the ancillary stream, tagged with the line's source, subject to channel selection. Nothing goes to the pixel stream.
- R7: For luma/chroma input (`cfg_rgb`=0), the sample phase counts 0,1,2,3 repeating from the first sample after the start code (or from a run start in discrete mode). Odd phases are luma and even phases are chroma. `cfg_anc_sel` selects: 0 = luma, 1 = chroma, 2 or 3 = both.
- R8: For three-colour input (`cfg_rgb`=1), the phase counts 0,1,2 repeating (R,G,B). `cfg_anc_sel` 0/1/2 keeps only that phase, and 3 keeps nothing.
- R9: In discrete mode, a sample with `de`=1 and `vsync`=0 is an active pixel with source 0, whatever `cfg_muxed` says, and the value 0xFF passes unchanged. `pix_sol` marks the first pixel of each run of `de`. `vblank` follows `vsync`, `hblank` follows the inverse of `de`, and `field` is 0, each one cycle later.
- R10: In discrete mode, a sample with `de`=1 and `vsync`=1 is a vertical-blanking ancillary sample with source 0. It is filtered by channel selection, with the phase counted from the start of its run.
- R11: Horizontal-blanking samples are captured only in discrete mode with `cfg_hanc`=1, at `de`=0 and `hsync`=1, filtered by channel selection. With `cfg_hanc`=0 they are dropped. In embedded mode, words between an end code and the next start code never reach either stream.
- R12: During reset, `pix_valid`, `anc_valid`, `field` and `code_err` are 0, and `vblank` and `hblank` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_embedded | input | 1 | 1 = timing from in-band codes, 0 = discrete sync pins |
| cfg_muxed | input | 1 | 1 = source index carried in the third code word (embedded only) |
| cfg_rgb | input | 1 | 1 = three-colour sample order, 0 = 4:2:2 luma/chroma order |
| cfg_anc_sel | input | 2 | Ancillary channel selection |
| cfg_hanc | input | 1 | Capture horizontal-blanking samples in discrete mode |
| din | input | DW | Sample word |
| hsync | input | 1 | Discrete horizontal sync |
| vsync | input | 1 | Discrete vertical sync |
| de | input | 1 | Discrete data enable |
| pix_valid | output | 1 | Active pixel present |
| pix_data | output | DW | Active pixel word |
| pix_src | output | SRC_W | Source index of the pixel |
| pix_sol | output | 1 | First pixel of a line |
| pix_sof | output | 1 | First pixel of a frame or field |
| anc_valid | output | 1 | Ancillary sample present |
| anc_data | output | DW | Ancillary sample word |
| anc_src | output | SRC_W | Source index of the ancillary sample |
| field | output | 1 | Recovered field flag |
| vblank | output | 1 | Recovered vertical-blanking flag |
| hblank | output | 1 | Recovered horizontal-blanking flag |
| code_err | output | 1 | Sticky flag set by a corrupt or rejected timing code |

## Verification
Frame start and line start fall on the same pixel. The bench opens vertical blanking with a V=1 code, follows it with active lines, and expects `pix_sof` and `pix_sol` together only on the first pixel of the first line. On every later line it expects `pix_sol` alone. A second collision arises when a corrupt start code arrives. The error flag rises in the same cycles in which the words that follow are dropped from the pixel stream. The bench judges both effects, and then shows that a later valid code opens a line while the flag stays set. In discrete mode, an active run directly follows a horizontal-blanking run. The bench then checks that the line-start marker and the restart of the channel phase happen on the same transition sample.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

   localparam int PH_W = 2;

   typedef enum logic [1:0] {
      TRS_IDLE,
      TRS_P1,
      TRS_P2,
      TRS_P3
   } vcp_trs_e;

   typedef enum logic [1:0] {
      CLS_NONE,
      CLS_ACT,
      CLS_VANC,
      CLS_HANC
   } vcp_class_e;

   // protection nibble for flags F, V, H
   function automatic logic [3:0] vcp_prot(input logic f, input logic v, input logic h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/vcp_trs_detect.sv
module vcp_trs_detect
   import vcp_pkg::*;
#(
   parameter int DW         = 8,
   parameter int SRC_W      = 4,
   parameter int MAX_SRC    = 9,
   parameter bit CHECK_PROT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             muxed,
   input  logic [DW-1:0]    din,
   output logic             suppress,
   output logic             code_ok,
   output logic             code_bad,
   output logic             code_f,
   output logic             code_v,
   output logic             code_h,
   output logic [SRC_W-1:0] code_src
);

   vcp_trs_e         st_q, st_d;
   logic [SRC_W-1:0] src_q, src_d;
   logic             prot_ok;
   logic             sword_ok;

   generate
      if (CHECK_PROT) begin : g_prot
         assign prot_ok = (din[DW-5 -: 4] == vcp_prot(din[DW-2], din[DW-3], din[DW-4]));
      end else begin : g_noprot
         assign prot_ok = 1'b1;
      end
   endgenerate

   assign sword_ok = ((din >> SRC_W) == '0) && (din[SRC_W-1:0] < SRC_W'(MAX_SRC));

   assign code_f   = din[DW-2];
   assign code_v   = din[DW-3];
   assign code_h   = din[DW-4];
   assign code_src = src_q;

   always_comb begin
      st_d     = st_q;
      src_d    = src_q;
      suppress = 1'b0;
      code_ok  = 1'b0;
      code_bad = 1'b0;
      if (!en) begin
         st_d = TRS_IDLE;
      end else begin
         unique case (st_q)
            TRS_IDLE: begin
               if (din == '1) begin
                  st_d     = TRS_P1;
                  suppress = 1'b1;
               end
            end
            TRS_P1: begin
               suppress = 1'b1;
               if (din == '0) begin
                  st_d = TRS_P2;
               end else begin
                  st_d     = TRS_IDLE;
                  code_bad = 1'b1;
               end
            end
            TRS_P2: begin
               suppress = 1'b1;
               if (muxed ? sword_ok : (din == '0)) begin
                  st_d  = TRS_P3;
                  src_d = muxed ? din[SRC_W-1:0] : '0;
               end else begin
                  st_d     = TRS_IDLE;
                  code_bad = 1'b1;
               end
            end
            default: begin
               suppress = 1'b1;
               st_d     = TRS_IDLE;
               if (din[DW-1] && prot_ok) code_ok  = 1'b1;
               else                      code_bad = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TRS_IDLE;
         src_q <= '0;
      end else begin
         st_q  <= st_d;
         src_q <= src_d;
      end
   end

endmodule

// File: rtl/vcp_chan_sel.sv
module vcp_chan_sel
   import vcp_pkg::*;
(
   input  logic            rgb,
   input  logic [1:0]      sel,
   input  logic [PH_W-1:0] phase,
   output logic            keep,
   output logic [PH_W-1:0] phase_nxt
);

   logic is_luma;

   assign is_luma = phase[0];

   always_comb begin
      if (rgb) begin
         keep      = (sel != 2'd3) && (phase == sel);
         phase_nxt = (phase == PH_W'(2)) ? '0 : phase + 1'b1;
      end else begin
         unique case (sel)
            2'd0:    keep = is_luma;
            2'd1:    keep = !is_luma;
            default: keep = 1'b1;
         endcase
         phase_nxt = phase + 1'b1;
      end
   end

endmodule

// File: rtl/vid_capture_parser.sv
module vid_capture_parser
   import vcp_pkg::*;
#(
   parameter int DW         = 8,
   parameter int SRC_W      = 4,
   parameter int MAX_SRC    = 9,
   parameter bit CHECK_PROT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_embedded,
   input  logic             cfg_muxed,
   input  logic             cfg_rgb,
   input  logic [1:0]       cfg_anc_sel,
   input  logic             cfg_hanc,
   input  logic [DW-1:0]    din,
   input  logic             hsync,
   input  logic             vsync,
   input  logic             de,
   output logic             pix_valid,
   output logic [DW-1:0]    pix_data,
   output logic [SRC_W-1:0] pix_src,
   output logic             pix_sol,
   output logic             pix_sof,
   output logic             anc_valid,
   output logic [DW-1:0]    anc_data,
   output logic [SRC_W-1:0] anc_src,
   output logic             field,
   output logic             vblank,
   output logic             hblank,
   output logic             code_err
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("vid_capture_parser: DW must be at least 8");
      end
      if (SRC_W >= DW) begin : g_bad_srcw
         $error("vid_capture_parser: SRC_W must be narrower than DW");
      end
      if (MAX_SRC < 1 || MAX_SRC > (1 << SRC_W)) begin : g_bad_max
         $error("vid_capture_parser: MAX_SRC out of range for SRC_W");
      end
   endgenerate

   logic             suppress, code_ok, code_bad;
   logic             code_f, code_v, code_h;
   logic [SRC_W-1:0] code_src;

   vcp_trs_detect #(
      .DW(DW), .SRC_W(SRC_W), .MAX_SRC(MAX_SRC), .CHECK_PROT(CHECK_PROT)
   ) u_trs (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_embedded),
      .muxed    (cfg_muxed),
      .din      (din),
      .suppress (suppress),
      .code_ok  (code_ok),
      .code_bad (code_bad),
      .code_f   (code_f),
      .code_v   (code_v),
      .code_h   (code_h),
      .code_src (code_src)
   );

   vcp_class_e       cls, prev_q;
   logic             run_start;
   logic [PH_W-1:0]  phase_q, ph_use, ph_nxt;
   logic             keep;
   logic             active_q, sol_pend_q, sof_pend_q;
   logic [SRC_W-1:0] src_q;

   always_comb begin
      if (de && !vsync)                  cls = CLS_ACT;
      else if (de && vsync)              cls = CLS_VANC;
      else if (!de && hsync && cfg_hanc) cls = CLS_HANC;
      else                               cls = CLS_NONE;
   end

   assign run_start = (cls != prev_q);
   assign ph_use    = (!cfg_embedded && run_start) ? '0 : phase_q;

   vcp_chan_sel u_sel (
      .rgb       (cfg_rgb),
      .sel       (cfg_anc_sel),
      .phase     (ph_use),
      .keep      (keep),
      .phase_nxt (ph_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_valid  <= 1'b0;
         pix_data   <= '0;
         pix_src    <= '0;
         pix_sol    <= 1'b0;
         pix_sof    <= 1'b0;
         anc_valid  <= 1'b0;
         anc_data   <= '0;
         anc_src    <= '0;
         field      <= 1'b0;
         vblank     <= 1'b1;
         hblank     <= 1'b1;
         code_err   <= 1'b0;
         active_q   <= 1'b0;
         sol_pend_q <= 1'b0;
         sof_pend_q <= 1'b0;
         src_q      <= '0;
         phase_q    <= '0;
         prev_q     <= CLS_NONE;
      end else begin
         pix_valid <= 1'b0;
         pix_sol   <= 1'b0;
         pix_sof   <= 1'b0;
         anc_valid <= 1'b0;
         pix_data  <= din;
         anc_data  <= din;
         if (code_bad) code_err <= 1'b1;

         if (cfg_embedded) begin
            prev_q <= CLS_NONE;
            if (code_ok) begin
               field    <= code_f;
               vblank   <= code_v;
               hblank   <= code_h;
               active_q <= !code_h;
               if (!code_h) begin
                  phase_q    <= '0;
                  src_q      <= code_src;
                  sol_pend_q <= 1'b1;
               end
               if (code_v) sof_pend_q <= 1'b1;
            end else if (!suppress && active_q) begin
               phase_q <= ph_nxt;
               if (!vblank) begin
                  pix_valid  <= 1'b1;
                  pix_src    <= src_q;
                  pix_sol    <= sol_pend_q;
                  pix_sof    <= sof_pend_q;
                  sol_pend_q <= 1'b0;
                  sof_pend_q <= 1'b0;
               end else begin
                  anc_valid <= keep;
                  anc_src   <= src_q;
               end
            end
         end else begin
            field    <= 1'b0;
            vblank   <= vsync;
            hblank   <= !de;
            active_q <= 1'b0;
            src_q    <= '0;
            prev_q   <= cls;
            phase_q  <= ph_nxt;
            if (vsync) sof_pend_q <= 1'b1;
            unique case (cls)
               CLS_ACT: begin
                  pix_valid  <= 1'b1;
                  pix_src    <= '0;
                  pix_sol    <= run_start;
                  pix_sof    <= sof_pend_q;
                  sof_pend_q <= 1'b0;
               end
               CLS_VANC, CLS_HANC: begin
                  anc_valid <= keep;
                  anc_src   <= '0;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/vcp_parser_chk.sv
module vcp_parser_chk #(
   parameter int DW      = 8,
   parameter int SRC_W   = 4,
   parameter int MAX_SRC = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_embedded,
   input logic             cfg_hanc,
   input logic [DW-1:0]    din,
   input logic             de,
   input logic             vsync,
   input logic             pix_valid,
   input logic [SRC_W-1:0] pix_src,
   input logic             pix_sol,
   input logic             pix_sof,
   input logic             anc_valid,
   input logic             code_err
);

   a_r1_ff_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_embedded && din == '1) |=> (!pix_valid && !anc_valid));

   a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |=> code_err);

   a_r4_sof_with_sol: assert property (@(posedge clk) disable iff (!rst_n)
      pix_sof |-> (pix_sol && pix_valid));

   a_r5_src_range: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (pix_src < SRC_W'(MAX_SRC)));

   a_r9_disc_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_embedded && de && !vsync) |=> (pix_valid && pix_src == '0));

   a_r11_hanc_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_embedded && !cfg_hanc && !de) |=> !anc_valid);

   a_r6_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_valid && anc_valid));

endmodule

bind vid_capture_parser vcp_parser_chk #(
   .DW(DW), .SRC_W(SRC_W), .MAX_SRC(MAX_SRC)
) u_chk (.*);

// File: tb/vid_capture_parser_bench.sv
module vid_capture_parser_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_embedded = 1'b1, cfg_muxed = 1'b0, cfg_rgb = 1'b0, cfg_hanc = 1'b0;
   logic [1:0] cfg_anc_sel = 2'd0;
   logic [7:0] din = 8'h00;
   logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0;

   logic       pix_valid, pix_sol, pix_sof, anc_valid;
   logic [7:0] pix_data, anc_data;
   logic [3:0] pix_src, anc_src;
   logic       field, vblank, hblank, code_err;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   vid_capture_parser u_vid_capture_parser (
      .clk(clk), .rst_n(rst_n), .cfg_embedded(cfg_embedded), .cfg_muxed(cfg_muxed),
      .cfg_rgb(cfg_rgb), .cfg_anc_sel(cfg_anc_sel), .cfg_hanc(cfg_hanc), .din(din),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_src(pix_src), .pix_sol(pix_sol), .pix_sof(pix_sof), .anc_valid(anc_valid),
      .anc_data(anc_data), .anc_src(anc_src), .field(field), .vblank(vblank),
      .hblank(hblank), .code_err(code_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   function automatic bit bkeep(input int i);
      if (cfg_rgb) return (cfg_anc_sel != 2'd3) && ((i % 3) == int'(cfg_anc_sel));
      if (cfg_anc_sel == 2'd0) return (i % 2) == 1;
      if (cfg_anc_sel == 2'd1) return (i % 2) == 0;
      return 1'b1;
   endfunction

   task automatic send(input logic [7:0] w);
      din = w;
      @(negedge clk);
   endtask

   task automatic dsend(input bit d, input bit hs, input bit vs, input logic [7:0] w);
      de = d; hsync = hs; vsync = vs; din = w;
      @(negedge clk);
   endtask

   task automatic quiet(input string req);
      chk(!pix_valid && !anc_valid, req, int'(pix_valid) + int'(anc_valid), 0);
   endtask

   task automatic code(input int src, input bit f, input bit v, input bit h,
                       input bit good, input bit corrupt);
      send(8'hFF); quiet("R1");
      send(8'h00); quiet("R1");
      send(cfg_muxed ? 8'(src) : 8'h00); quiet("R1");
      send(xy(f, v, h) ^ {7'd0, corrupt}); quiet("R1");
      if (good && !corrupt) begin
         chk(field == f,  "R1 field",  int'(field),  int'(f));
         chk(vblank == v, "R1 vblank", int'(vblank), int'(v));
         chk(hblank == h, "R1 hblank", int'(hblank), int'(h));
      end
   endtask

   task automatic vanc_line(input int src, input int n, input string req);
      code(src, 0, 1, 0, 1, 0);
      for (int i = 0; i < n; i++) begin
         send(8'h20 + 8'(i));
         chk(anc_valid == bkeep(i), req, int'(anc_valid), int'(bkeep(i)));
         chk(!pix_valid, "R6 no pixel", int'(pix_valid), 0);
         if (bkeep(i)) begin
            chk(anc_data == 8'h20 + 8'(i), "R6 data", int'(anc_data), 32 + i);
            chk(int'(anc_src) == src, "R5 anc src", int'(anc_src), src);
         end
      end
      code(src, 0, 1, 1, 1, 0);
   endtask

   task automatic act_line(input int src, input int n, input bit exp_sof);
      code(src, 0, 0, 0, 1, 0);
      for (int i = 0; i < n; i++) begin
         send(8'h40 + 8'(i));
         chk(pix_valid, "R3 valid", int'(pix_valid), 1);
         chk(pix_data == 8'h40 + 8'(i), "R3 data", int'(pix_data), 64 + i);
         chk(int'(pix_src) == src, "R5 pix src", int'(pix_src), src);
         chk(pix_sol == (i == 0), "R3 sol", int'(pix_sol), int'(i == 0));
         chk(pix_sof == (exp_sof && i == 0), "R4 sof", int'(pix_sof), int'(exp_sof && i == 0));
      end
      code(src, 0, 0, 1, 1, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!pix_valid && !anc_valid, "R12 valids", int'(pix_valid) + int'(anc_valid), 0);
      chk(vblank && hblank, "R12 blank flags", int'(vblank) + int'(hblank), 2);
      chk(!field && !code_err, "R12 field/err", int'(field) + int'(code_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // luma/chroma channel sweep on vertical-blanking lines (R6, R7)
      for (int s = 0; s < 4; s++) begin
         cfg_anc_sel = 2'(s);
         vanc_line(0, 8, "R7 yuv select");
      end

      // horizontal blanking words in embedded mode (R11)
      for (int i = 0; i < 3; i++) begin
         send(8'h55);
         quiet("R11 embedded hblank");
      end

      act_line(0, 6, 1'b1);
      act_line(0, 6, 1'b0);
      chk(!code_err, "R2 no error on good codes", int'(code_err), 0);

      code(0, 1, 1, 1, 1, 0);

      // multiplexed sources 0..8 (R5)
      cfg_muxed = 1'b1;
      for (int s = 0; s < 9; s++) act_line(s, 4, s == 0);
      cfg_anc_sel = 2'd2;
      vanc_line(8, 4, "R6 split source anc");

      // three-colour channel sweep (R8)
      cfg_muxed = 1'b0;
      cfg_rgb   = 1'b1;
      for (int s = 0; s < 4; s++) begin
         cfg_anc_sel = 2'(s);
         vanc_line(0, 7, "R8 rgb select");
      end

      // discrete sync (R9, R10, R11)
      cfg_embedded = 1'b0;
      cfg_muxed    = 1'b1;
      cfg_rgb      = 1'b0;
      cfg_anc_sel  = 2'd1;
      for (int i = 0; i < 4; i++) begin
         dsend(1, 0, 1, 8'h60 + 8'(i));
         chk(anc_valid == bkeep(i), "R10 vanc select", int'(anc_valid), int'(bkeep(i)));
         if (bkeep(i)) chk(anc_data == 8'h60 + 8'(i), "R10 data", int'(anc_data), 96 + i);
         chk(vblank && !hblank, "R9 flags vanc", int'(vblank), 1);
      end
      for (int i = 0; i < 3; i++) begin
         dsend(0, 1, 0, 8'h70);
         chk(!anc_valid && !pix_valid, "R11 hanc off", int'(anc_valid), 0);
         chk(hblank && !vblank, "R9 flags hblank", int'(hblank), 1);
      end
      for (int i = 0; i < 4; i++) begin
         logic [7:0] w;
         w = (i == 2) ? 8'hFF : 8'h80 + 8'(i);
         dsend(1, 0, 0, w);
         chk(pix_valid && pix_data == w, "R9 pixel", int'(pix_data), int'(w));
         chk(pix_src == 4'd0, "R9 src zero", int'(pix_src), 0);
         chk(pix_sol == (i == 0), "R9 sol", int'(pix_sol), int'(i == 0));
         chk(pix_sof == (i == 0), "R4 discrete sof", int'(pix_sof), int'(i == 0));
         chk(!field, "R9 field", int'(field), 0);
      end
      cfg_hanc = 1'b1;
      for (int i = 0; i < 4; i++) begin
         dsend(0, 1, 0, 8'h90 + 8'(i));
         chk(anc_valid == bkeep(i), "R11 hanc select", int'(anc_valid), int'(bkeep(i)));
      end
      for (int i = 0; i < 3; i++) begin
         dsend(1, 0, 0, 8'hA0 + 8'(i));
         chk(pix_sol == (i == 0), "R9 sol after hanc", int'(pix_sol), int'(i == 0));
         chk(!pix_sof, "R4 no second sof", int'(pix_sof), 0);
      end
      dsend(0, 0, 0, 8'h00);

      // corrupt code (R2)
      cfg_embedded = 1'b1;
      cfg_muxed    = 1'b0;
      cfg_hanc     = 1'b0;
      code(0, 0, 1, 1, 1, 0);
      chk(!code_err, "R2 clean before", int'(code_err), 0);
      code(0, 0, 0, 0, 1, 1);
      chk(code_err, "R2 error set", int'(code_err), 1);
      for (int i = 0; i < 3; i++) begin
         send(8'h44);
         quiet("R2 corrupt code ignored");
         chk(hblank, "R2 flags kept", int'(hblank), 1);
      end
      act_line(0, 3, 1'b1);
      chk(code_err, "R2 error sticky", int'(code_err), 1);

      // rejected source index (R5)
      cfg_muxed = 1'b1;
      code(9, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) begin
         send(8'h33);
         quiet("R5 index 9 rejected");
         chk(hblank, "R5 line not opened", int'(hblank), 1);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule